// File: doc/BRIEF.md
# Flag-Setting Add Execute Unit

This unit executes the flag-setting integer add instructions of a 64-bit load/store architecture. It receives a 32-bit instruction word with two operand values already fetched from the register file. It recognises three encodings of the add: register with shift, register with extension, and 12-bit immediate. It forms the second operand for the recognised encoding and adds it to the first with no carry in. From the sum it derives the negative, zero, carry and overflow condition flags.

The source register numbers are decoded combinationally and driven out to the register-read port. The result, destination index, flags and strobes are captured in registers and appear one clock after the instruction is presented with `in_valid`. Bit 31 of the word selects the operation width: 32 bits or 64 bits. A word the unit cannot execute raises `undef` and suppresses both writes.

Top module: `flagadd_exec`

## Requirements
- R1: `out_valid` rises in the cycle after a cycle in which `in_valid` was high, and is low otherwise. When `out_valid` is low, `rd_we`, `nzcv_we` and `undef` are all low.
- R2: Bit 31 of `instr` selects the width: 0 means 32 bits and 1 means 64 bits. In 32-bit mode, bits 63:32 of both operands are ignored and `rd_data[63:32]` is zero.
- R3: A word with bits 30:29 = 01, bits 28:24 = 01011 and bit 21 = 0 is a shifted-register add. The second operand is `opb` shifted by `instr[15:10]`. `instr[23:22]` selects the shift: 00 is a left shift, 01 is a logical right shift and 10 is an arithmetic right shift.
- R4: A word with bits 30:29 = 01, bits 28:24 = 01011, bits 23:22 = 00 and bit 21 = 1 is an extended-register add. `instr[14:13]` picks the low 8, 16, 32 or 64 bits of `opb`. `instr[15]` = 1 sign-extends that value and 0 zero-extends it. The extended value is then shifted left by `instr[12:10]`.
- R5: A word with bits 30:29 = 01 and bits 28:23 = 100010 is an immediate add. The second operand is the zero-extended `instr[21:10]`, shifted left by 12 when `instr[22]` = 1.
- R6: `nzcv` carries N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. N is the top bit of the result at the operation width. Z is set when the result is zero. C is the unsigned carry out of the top bit. V is set when both operands share a sign and the result has the other sign.
- R7: `undef` is raised for any of these cases: the word matches none of the three layouts; the shift code is 11; the shift amount is 32 or more in 32-bit mode; bits 23:22 are not 00 in the extended layout; the extend shift is greater than 4. When `undef` is raised, `rd_we` and `nzcv_we` are low.
- R8: For a valid, defined word, `rd_we` and `nzcv_we` are both high, `rd_idx` equals `instr[4:0]` and `rd_data` holds the sum. The combinational outputs `rn_sel` and `rm_sel` always equal `instr[9:5]` and `instr[20:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 64 | Value read for the first source register |
| opb | input | 64 | Value read for the second source register |
| rn_sel | output | 5 | First source index, combinational |
| rm_sel | output | 5 | Second source index, combinational |
| out_valid | output | 1 | Registered outputs hold a result |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Sum, zero-extended in 32-bit mode |
| rd_we | output | 1 | Register write strobe |
| nzcv | output | 4 | New condition flags |
| nzcv_we | output | 1 | Flag update strobe |
| undef | output | 1 | Word is not an executable flag-setting add |

## Verification
The assertions assume that `in_valid` is a clean, defined level at every clock edge. They also assume that `instr`, `opa` and `opb` are stable whenever `in_valid` is high.

The bench meets both assumptions by changing every input only on the falling edge. It holds `in_valid` low while reset is active. Each instruction is presented for exactly one cycle, and the outputs are read on the next falling edge.

// File: rtl/flagadd_exec.sv
module flagadd_exec #(
  parameter int XW = 64,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [XW-1:0] opa,
  input  logic [XW-1:0] opb,
  output logic [RW-1:0] rn_sel,
  output logic [RW-1:0] rm_sel,
  output logic          out_valid,
  output logic [RW-1:0] rd_idx,
  output logic [XW-1:0] rd_data,
  output logic          rd_we,
  output logic [3:0]    nzcv,
  output logic          nzcv_we,
  output logic          undef
);
  localparam int HW = XW / 2;

  wire sf     = instr[31];
  wire pre_ok = instr[30:29] == 2'b01;
  wire is_sh  = pre_ok && instr[28:24] == 5'b01011 && !instr[21];
  wire is_ext = pre_ok && instr[28:24] == 5'b01011 && instr[21];
  wire is_imm = pre_ok && instr[28:23] == 6'b100010;

  wire [1:0]  sh_typ = instr[23:22];
  wire [5:0]  sh_amt = instr[15:10];
  wire [2:0]  ex_opt = instr[15:13];
  wire [2:0]  ex_amt = instr[12:10];
  wire [11:0] imm12  = instr[21:10];

  assign rn_sel = instr[9:5];
  assign rm_sel = instr[20:16];

  wire [XW-1:0] a_op = sf ? opa : {{HW{1'b0}}, opa[HW-1:0]};
  wire [XW-1:0] m_op = sf ? opb : {{HW{1'b0}}, opb[HW-1:0]};

  logic [XW-1:0] sh_val, ex_src, ex_val, imm_val, b_raw;

  always_comb begin
    case (sh_typ)
      2'b01:   sh_val = m_op >> sh_amt;
      2'b10:   sh_val = sf ? XW'($signed(m_op) >>> sh_amt)
                           : {{HW{1'b0}}, HW'($signed(m_op[HW-1:0]) >>> sh_amt[4:0])};
      default: sh_val = m_op << sh_amt;
    endcase
  end

  always_comb begin
    case (ex_opt[1:0])
      2'b00:   ex_src = ex_opt[2] ? {{(XW-8){opb[7]}}, opb[7:0]}     : {{(XW-8){1'b0}}, opb[7:0]};
      2'b01:   ex_src = ex_opt[2] ? {{(XW-16){opb[15]}}, opb[15:0]}  : {{(XW-16){1'b0}}, opb[15:0]};
      2'b10:   ex_src = ex_opt[2] ? {{(XW-32){opb[31]}}, opb[31:0]}  : {{(XW-32){1'b0}}, opb[31:0]};
      default: ex_src = opb;
    endcase
    ex_val = ex_src << ex_amt;
  end

  assign imm_val = {{(XW-12){1'b0}}, imm12} << (instr[22] ? 12 : 0);

  always_comb begin
    if (is_imm)      b_raw = imm_val;
    else if (is_ext) b_raw = ex_val;
    else             b_raw = sh_val;
  end

  wire [XW-1:0] b_op = sf ? b_raw : {{HW{1'b0}}, b_raw[HW-1:0]};
  wire [XW:0]   sum  = {1'b0, a_op} + {1'b0, b_op};
  wire [XW-1:0] res  = sf ? sum[XW-1:0] : {{HW{1'b0}}, sum[HW-1:0]};

  wire a_top = sf ? a_op[XW-1] : a_op[HW-1];
  wire b_top = sf ? b_op[XW-1] : b_op[HW-1];
  wire r_top = sf ? res[XW-1]  : res[HW-1];
  wire f_n   = r_top;
  wire f_z   = res == '0;
  wire f_c   = sf ? sum[XW] : sum[HW];
  wire f_v   = (a_top == b_top) && (r_top != a_top);

  wire ok_sh  = is_sh && sh_typ != 2'b11 && (sf || !sh_amt[5]);
  wire ok_ext = is_ext && instr[23:22] == 2'b00 && ex_amt <= 3'd4;
  wire bad    = !(ok_sh || ok_ext || is_imm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
      rd_we     <= 1'b0;
      nzcv      <= 4'b0000;
      nzcv_we   <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      rd_we     <= in_valid && !bad;
      nzcv_we   <= in_valid && !bad;
      undef     <= in_valid && bad;
      if (in_valid) begin
        rd_idx  <= instr[4:0];
        rd_data <= res;
        nzcv    <= {f_n, f_z, f_c, f_v};
      end
    end
  end
endmodule

// File: rtl/flagadd_exec_chk.sv
module flagadd_exec_chk #(
  parameter int XW = 64,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [XW-1:0] rd_data,
  input logic          rd_we,
  input logic [3:0]    nzcv,
  input logic          nzcv_we,
  input logic          undef
);
  // R1
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !rd_we && !nzcv_we && !undef);

  // R7
  undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !rd_we && !nzcv_we);

  // R8
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rd_we == nzcv_we) && (rd_we != undef));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nzcv_we |-> nzcv[2] == (rd_data == '0));
endmodule

bind flagadd_exec flagadd_exec_chk #(.XW(XW), .RW(RW)) u_chk (.*);

// File: tb/sim_flagadd_exec.sv
`timescale 1ns/1ps
module sim_flagadd_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [4:0]  rn_sel, rm_sel, rd_idx;
  logic        out_valid, rd_we, nzcv_we, undef;
  logic [63:0] rd_data;
  logic [3:0]  nzcv;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flagadd_exec u0 (.*);

  function automatic logic [31:0] enc_sh(bit sf, logic [1:0] st, logic [4:0] rm, logic [5:0] amt, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b01, 5'b01011, st, 1'b0, rm, amt, rn, rd};
  endfunction
  function automatic logic [31:0] enc_ext(bit sf, logic [2:0] opt, logic [2:0] amt, logic [4:0] rm, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b01, 5'b01011, 2'b00, 1'b1, rm, opt, amt, rn, rd};
  endfunction
  function automatic logic [31:0] enc_imm(bit sf, bit sh, logic [11:0] imm, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b01, 6'b100010, sh, imm, rn, rd};
  endfunction

  // expected {nzcv, sum} from the requirement text, using wide arithmetic
  function automatic logic [67:0] model(bit sf, logic [63:0] a, logic [63:0] b);
    logic [127:0] ua, ub, s;
    logic signed [127:0] sa, sb, ss, lim;
    logic [63:0] r;
    logic n, z, c, v;
    ua = sf ? {64'b0, a} : {96'b0, a[31:0]};
    ub = sf ? {64'b0, b} : {96'b0, b[31:0]};
    s = ua + ub;
    r = sf ? s[63:0] : {32'b0, s[31:0]};
    c = sf ? s[64] : s[32];
    sa = sf ? 128'($signed(a)) : 128'($signed(a[31:0]));
    sb = sf ? 128'($signed(b)) : 128'($signed(b[31:0]));
    ss = sa + sb;
    lim = sf ? (128'sd1 <<< 63) : (128'sd1 <<< 31);
    v = (ss >= lim) || (ss < -lim);
    n = sf ? r[63] : r[31];
    z = r == 64'b0;
    return {n, z, c, v, r};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    instr = w; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_good(string req, logic [31:0] w, logic [63:0] a, logic [63:0] b, logic [63:0] beff);
    logic [67:0] e;
    e = model(w[31], a, b == b ? beff : beff);
    apply(w, a, b);
    check(req, "rd_data", rd_data, e[63:0]);
    check(req, "nzcv", {60'b0, nzcv}, {60'b0, e[67:64]});
    check(req, "we/undef", {61'b0, rd_we, nzcv_we, undef}, 64'b110);
    check("R8", "rd_idx", {59'b0, rd_idx}, {59'b0, w[4:0]});
  endtask

  task automatic run_bad(string req, logic [31:0] w);
    apply(w, 64'h1234, 64'h5678);
    check(req, "out_valid/we/nzcv_we/undef", {60'b0, out_valid, rd_we, nzcv_we, undef}, 64'b1001);
  endtask

  task automatic t_reset;
    check("R1", "reset out_valid/we/undef", {60'b0, out_valid, rd_we, nzcv_we, undef}, 64'b0);
  endtask

  task automatic t_shifted;
    // R3 R6: signed overflow into negative
    run_good("R3", enc_sh(0, 2'b00, 5'd2, 6'd0, 5'd1, 5'd0), 64'h7FFF_FFFF, 64'h1, 64'h1);
    // R2: upper operand bits ignored, wrap to zero with carry
    run_good("R2", enc_sh(0, 2'b00, 5'd3, 6'd0, 5'd4, 5'd5), 64'hDEAD_BEEF_FFFF_FFFF, 64'hCAFE_0000_0000_0001, 64'h1);
    check("R2", "rd_data upper", rd_data[63:32], 32'h0);
    check("R6", "wrap flags", {60'b0, nzcv}, 64'b0110);
    run_good("R3", enc_sh(1, 2'b00, 5'd7, 6'd4, 5'd8, 5'd9), 64'h1, 64'h0F00_0000_0000_0000, 64'hF000_0000_0000_0000);
    run_good("R3", enc_sh(1, 2'b01, 5'd7, 6'd8, 5'd8, 5'd10), 64'h5, 64'hFF00, 64'hFF);
    run_good("R3", enc_sh(0, 2'b10, 5'd1, 6'd4, 5'd2, 5'd11), 64'h0800_0000, 64'h8000_0000, 64'hF800_0000);
    check("R6", "asr zero+carry", {60'b0, nzcv}, 64'b0110);
  endtask

  task automatic t_extended;
    run_good("R4", enc_ext(1, 3'b100, 3'd2, 5'd3, 5'd4, 5'd12), 64'h200, 64'h80, 64'hFFFF_FFFF_FFFF_FE00);
    run_good("R4", enc_ext(0, 3'b001, 3'd1, 5'd3, 5'd4, 5'd13), 64'h10, 64'hFFFF_8001, 64'h1_0002);
    run_good("R4", enc_ext(1, 3'b110, 3'd0, 5'd3, 5'd4, 5'd14), 64'h8000_0000_0000_0000, 64'h8000_0000, 64'hFFFF_FFFF_8000_0000);
    check("R6", "sxtw overflow", {60'b0, nzcv}, 64'b0011);
  endtask

  task automatic t_immediate;
    run_good("R5", enc_imm(0, 1'b1, 12'hABC, 5'd6, 5'd15), 64'h1, 64'h0, 64'hAB_C000);
    check("R5", "imm<<12 sum", rd_data, 64'hAB_C001);
    run_good("R5", enc_imm(1, 1'b0, 12'hFFF, 5'd6, 5'd16), 64'hFFFF_FFFF_FFFF_F001, 64'h0, 64'hFFF);
    check("R6", "imm wrap flags", {60'b0, nzcv}, 64'b0110);
  endtask

  task automatic t_undef;
    run_bad("R7", enc_sh(1, 2'b11, 5'd1, 6'd0, 5'd1, 5'd1));
    run_bad("R7", enc_sh(0, 2'b00, 5'd1, 6'd32, 5'd1, 5'd1));
    run_bad("R7", enc_ext(1, 3'b010, 3'd5, 5'd1, 5'd1, 5'd1));
    run_bad("R7", enc_ext(1, 3'b010, 3'd0, 5'd1, 5'd1, 5'd1) | 32'h0040_0000);
    run_bad("R7", 32'h8B00_0000);
    run_bad("R7", 32'h0000_0000);
  endtask

  task automatic t_idle_sel;
    @(negedge clk);
    instr = enc_sh(1, 2'b00, 5'd21, 6'd0, 5'd17, 5'd3);
    #1;
    check("R8", "rn_sel", {59'b0, rn_sel}, 64'd17);
    check("R8", "rm_sel", {59'b0, rm_sel}, 64'd21);
    @(negedge clk);
    check("R1", "idle strobes", {60'b0, out_valid, rd_we, nzcv_we, undef}, 64'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_shifted();
    t_extended();
    t_immediate();
    t_undef();
    t_idle_sel();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule